// File: doc/BRIEF.md
# Byte-Lane Data Memory with Load/Store Formatting

This block is the data-side memory of a 32-bit core. It stores 4096 words of four bytes each. The word index is the 12 bits just above the two lane bits of the byte address. A single request strobe, a direction bit and a 3-bit width code select one of three operations: a full-word access, an access to one byte lane, or an access to one half of the word. The address arrives already computed, so this block only selects lanes and formats data.

Stores take effect on the rising clock edge. A narrow store changes only the addressed lanes of the word. Loads are registered. The formatted result, sign- or zero-extended as the code asks, appears on the load-data output one cycle after the request and holds until the next valid load. A request that carries an undefined code does not touch the memory and raises a one-cycle error flag.

Top module: `lsu_bytemem`

## Requirements
- R1: While reset is asserted and directly after it is released, `rdata` is 0 and `err` is 0.
- R2: A load with code 000 or 001 returns the full word `mem[addr[13:2]]` on `rdata` in the cycle after the request. `addr[1:0]` is ignored.
- R3: A load with code 010 returns the byte in lane `addr[1:0]` (lane 0 = bits 7:0, little-endian), sign-extended from bit 7.
- R4: A load with code 011 returns the same byte, zero-extended.
- R5: Loads with codes 100 and 101 return the half selected by `addr[1]` (0 = bits 15:0, 1 = bits 31:16). Code 100 sign-extends it and code 101 zero-extends it.
- R6: A store with code 000 or 001 writes all 32 bits of `wdata` to the addressed word.
- R7: A store with code 010 writes `wdata[7:0]` into lane `addr[1:0]` only. The other three bytes of the word are unchanged.
- R8: A store with code 011 writes `wdata[15:0]` into the half selected by `addr[1]` only. The other half is unchanged.
- R9: A load with code 110 or 111, or a store with a code of 100 to 111, performs no access. It leaves memory and `rdata` unchanged and sets `err` high for exactly the next cycle. Valid requests leave `err` low.
- R10: While `req` is low, memory and `rdata` hold their values and `err` is low in the following cycle. A valid store also leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset for the output registers |
| req | input | 1 | Access strobe |
| is_store | input | 1 | 1 = store, 0 = load |
| funct | input | 3 | Width/extension code |
| addr | input | 14 | Byte address: bits 13:2 select the word, bits 1:0 select the lane |
| wdata | input | 32 | Store data, taken from its low lanes |
| rdata | output | 32 | Formatted load data, registered |
| err | output | 1 | Undefined-code flag, registered |

## Verification
The assertions check on every cycle the properties that follow from the request alone. Undefined codes must raise `err` and valid or idle cycles must not. `rdata` must stay stable after stores, idle cycles and rejected loads. The upper bits of `rdata` must match the sign or zero extension that the code asks for.

Only the bench's scenarios can show lane selection, the preserved neighbouring bytes after a narrow store, and the data values themselves. For these it keeps a byte-level model of the whole memory and compares every load against that model. This includes loads that follow stores whose codes were rejected.

// File: rtl/lsu_bytemem.sv
module lsu_bytemem #(
  parameter int WORDS = 4096,
  localparam int IW = $clog2(WORDS),
  localparam int AW = IW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          is_store,
  input  logic [2:0]    funct,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          err
);

  logic [31:0] mem [WORDS];

  wire [IW-1:0] widx   = addr[AW-1:2];
  wire [1:0]    lane   = addr[1:0];
  wire [31:0]   word   = mem[widx];
  wire [7:0]    byte_v = word[8*lane +: 8];
  wire [15:0]   half_v = addr[1] ? word[31:16] : word[15:0];
  wire          ld_ok  = funct[2:1] != 2'b11;
  wire          st_ok  = !funct[2];

  logic [31:0] ld_fmt;
  always_comb begin
    case (funct)
      3'b010:  ld_fmt = {{24{byte_v[7]}}, byte_v};
      3'b011:  ld_fmt = {24'd0, byte_v};
      3'b100:  ld_fmt = {{16{half_v[15]}}, half_v};
      3'b101:  ld_fmt = {16'd0, half_v};
      default: ld_fmt = word;
    endcase
  end

  logic [3:0]  be;
  logic [31:0] wd;
  always_comb begin
    case (funct)
      3'b000, 3'b001: begin be = 4'hf;                        wd = wdata;              end
      3'b010:         begin be = 4'b0001 << lane;             wd = {4{wdata[7:0]}};    end
      3'b011:         begin be = addr[1] ? 4'b1100 : 4'b0011; wd = {2{wdata[15:0]}};   end
      default:        begin be = 4'h0;                        wd = wdata;              end
    endcase
  end

  always_ff @(posedge clk) begin
    if (req && is_store) begin
      for (int i = 0; i < 4; i++)
        if (be[i]) mem[widx][8*i +: 8] <= wd[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      err <= req && (is_store ? !st_ok : !ld_ok);
      if (req && !is_store && ld_ok) rdata <= ld_fmt;
    end
  end

endmodule

// File: rtl/lsu_bytemem_chk.sv
module lsu_bytemem_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          is_store,
  input logic [2:0]    funct,
  input logic [AW-1:0] addr,
  input logic [31:0]   rdata,
  input logic          err
);

  wire bad_ld = req && !is_store && (funct[2:1] == 2'b11);
  wire bad_st = req && is_store && funct[2];

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |-> (rdata == 32'd0 && !err));

  p_err_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_ld || bad_st) |=> err);

  p_err_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !bad_ld && !bad_st) |=> !err);

  p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !err);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req || is_store || bad_ld) |=> $stable(rdata));

  p_sext_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !is_store && funct == 3'b010) |=> (rdata[31:8] == {24{rdata[7]}}));

  p_zext_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !is_store && funct == 3'b011) |=> (rdata[31:8] == 24'd0));

  p_ext_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !is_store && funct[2:1] == 2'b10) |=>
      (rdata[31:16] == (($past(funct[0])) ? 16'd0 : {16{rdata[15]}})));

endmodule

bind lsu_bytemem lsu_bytemem_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .is_store(is_store),
  .funct(funct), .addr(addr), .rdata(rdata), .err(err)
);

// File: tb/lsu_bytemem_test.sv
`timescale 1ns/1ps
module lsu_bytemem_test;
  localparam int AW = 14;
  localparam int NB = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, is_store = 1'b0;
  logic [2:0] funct = 3'd0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic err;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] mb [NB];
  logic [31:0] exp_rd = 32'd0;

  always #2.5 clk = ~clk;

  lsu_bytemem uut (.clk(clk), .rst_n(rst_n), .req(req), .is_store(is_store),
                   .funct(funct), .addr(addr), .wdata(wdata), .rdata(rdata), .err(err));

  function automatic logic [31:0] mword(logic [AW-1:0] a);
    logic [AW-1:0] b = {a[AW-1:2], 2'b00};
    return {mb[b+3], mb[b+2], mb[b+1], mb[b]};
  endfunction

  function automatic logic [31:0] exp_load(logic [2:0] f, logic [AW-1:0] a);
    logic [31:0] w = mword(a);
    logic [7:0]  by = mb[a];
    logic [15:0] h = a[1] ? w[31:16] : w[15:0];
    case (f)
      3'b010:  return {{24{by[7]}}, by};
      3'b011:  return {24'd0, by};
      3'b100:  return {{16{h[15]}}, h};
      3'b101:  return {16'd0, h};
      default: return w;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
    end
  endtask

  function automatic string ld_tag(logic [2:0] f);
    case (f)
      3'b010:         return "R3";
      3'b011:         return "R4";
      3'b100, 3'b101: return "R5";
      3'b110, 3'b111: return "R9";
      default:        return "R2";
    endcase
  endfunction

  task automatic op(logic st, logic [2:0] f, logic [AW-1:0] a, logic [31:0] d, bit check);
    logic bad;
    req = 1'b1; is_store = st; funct = f; addr = a; wdata = d;
    bad = st ? f[2] : (f[2:1] == 2'b11);
    if (!st && !bad) exp_rd = exp_load(f, a);
    if (st && !bad) begin
      logic [AW-1:0] b = {a[AW-1:2], 2'b00};
      case (f)
        3'b000, 3'b001: for (int i = 0; i < 4; i++) mb[b+i] = d[8*i +: 8];
        3'b010: mb[a] = d[7:0];
        3'b011: begin
          mb[{a[AW-1:1], 1'b0}] = d[7:0];
          mb[{a[AW-1:1], 1'b1}] = d[15:8];
        end
        default: ;
      endcase
    end
    @(negedge clk);
    if (check) begin
      chk(st ? (bad ? "R9 store err" : "R6/R7/R8 store err") : {ld_tag(f), " err"}, {31'd0, err}, {31'd0, bad});
      chk(st ? "R10 rdata after store" : {ld_tag(f), " rdata"}, rdata, exp_rd);
    end
  endtask

  task automatic idle(int n);
    req = 1'b0;
    repeat (n) begin
      @(negedge clk);
      chk("R10 idle err", {31'd0, err}, 32'd0);
      chk("R10 idle rdata", rdata, exp_rd);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250522));
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", rdata, 32'd0);
    chk("R1 reset err", {31'd0, err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset rdata", rdata, 32'd0);
    chk("R1 post-reset err", {31'd0, err}, 32'd0);

    for (int w = 0; w < NB / 4; w++) op(1'b1, 3'b000, AW'(w * 4), $urandom, 1'b0);

    // directed corners
    op(1'b1, 3'b001, 14'h0010, 32'h8070_F001, 1'b1);          // R6
    op(1'b0, 3'b001, 14'h0013, 32'd0, 1'b1);                  // R2 lane bits ignored
    for (int l = 0; l < 4; l++) op(1'b0, 3'b010, AW'(16 + l), 32'd0, 1'b1); // R3
    for (int l = 0; l < 4; l++) op(1'b0, 3'b011, AW'(16 + l), 32'd0, 1'b1); // R4
    op(1'b0, 3'b100, 14'h0012, 32'd0, 1'b1);                  // R5 upper half sign
    op(1'b0, 3'b101, 14'h0012, 32'd0, 1'b1);                  // R5 upper half zero
    op(1'b1, 3'b010, 14'h0011, 32'hFFFF_FFAA, 1'b1);          // R7 lane 1 only
    op(1'b0, 3'b000, 14'h0010, 32'd0, 1'b1);
    op(1'b1, 3'b011, 14'h0012, 32'h1234_5678, 1'b1);          // R8 upper half only
    op(1'b0, 3'b000, 14'h0010, 32'd0, 1'b1);
    op(1'b1, 3'b101, 14'h0010, 32'hDEAD_BEEF, 1'b1);          // R9 bad store
    op(1'b0, 3'b110, 14'h0010, 32'd0, 1'b1);                  // R9 bad load
    op(1'b0, 3'b000, 14'h0010, 32'd0, 1'b1);                  // R9 memory untouched
    op(1'b1, 3'b000, 14'h3FFC, 32'h0000_0000, 1'b1);          // top word
    op(1'b0, 3'b111, 14'h3FFC, 32'd0, 1'b1);
    op(1'b0, 3'b000, 14'h3FFF, 32'd0, 1'b1);
    idle(3);

    for (int k = 0; k < 6000; k++) begin
      logic st = 1'($urandom);
      op(st, 3'($urandom), AW'($urandom), $urandom, 1'b1);
      if (($urandom % 16) == 0) idle(1);
    end
    idle(2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule